// File: doc/BRIEF.md
# TCP Connection Timer Supervisor

This block watches over a single TCP connection and owns all of its time limits. It keeps the connection phase (idle, listening, connecting, connected, closing) from the open and close commands and from segment events that a receive decoder has already classified. It does not build segments, track sequence numbers or hold payload. Its outputs are one-hot phase flags plus three single-cycle pulses: a request to resend the oldest unacknowledged segment, a request to send a keepalive probe, and an abort that drops the connection.

Four rules can end a connection, and they all lead to the same abort pulse. The handshake or the teardown runs past its deadline. A segment is resent the allowed number of times and still gets no acknowledgement. A quiet link is probed the allowed number of times and never answers. Every interval is a parameter counted in clock ticks. The defaults match 10 ms, 1 s, 5 s and 100 ms at 125 MHz, and a testbench can make them small.

Top module: `tcp_conn_supervisor`

## Requirements
- R1: After reset the phase is idle. At all times exactly one of st_idle, st_listening, st_connecting, st_connected, st_closing is high.
- R2: Phase moves are as follows. From idle, cmd_connect goes to connecting and takes priority over cmd_listen, and cmd_listen alone goes to listening. From listening, ev_rx_valid goes to connecting and cmd_close goes to idle. From connecting, ev_synack or ev_ack goes to connected, and cmd_close goes to closing. From connected, cmd_close goes to closing. From closing, ev_fin_done goes to idle. Each move is visible one cycle after the input.
- R3: In connecting or closing, abort_req pulses in the CONN_TIMEOUT_TICKS-th cycle of that phase, counting the first cycle as 1, unless a move that leaves the phase happens in that same cycle. Listening never times out.
- R4: While connected with tx_unacked high, rtx_req pulses for one cycle every RTX_TICKS cycles. The count starts with the first cycle tx_unacked is high. ev_ack restarts the interval and clears the resend count, and no rtx_req is raised in the cycle of an ev_ack.
- R5: After RTX_TRIES resend requests with no ev_ack, the next expiry raises abort_req and not rtx_req.
- R6: While connected with KA_ENABLE set, ka_req pulses after KA_PERIOD_TICKS cycles in which ev_rx_valid stays low.
- R7: After the first probe, more probes follow every KA_RETRY_TICKS cycles. Once KA_TRIES probes have gone unanswered, the next expiry raises abort_req and not ka_req.
- R8: ev_rx_valid in connected restarts the quiet interval at KA_PERIOD_TICKS and clears the probe count. No ka_req or keepalive abort is raised in that cycle.
- R9: With KA_ENABLE cleared, ka_req never rises and a quiet link stays connected.
- R10: abort_req lasts exactly one cycle, and the phase is idle in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_connect | input | 1 | Open actively |
| cmd_listen | input | 1 | Wait for a remote open |
| cmd_close | input | 1 | Start teardown |
| ev_synack | input | 1 | SYN-ACK received |
| ev_ack | input | 1 | Acknowledgement received |
| ev_fin_done | input | 1 | FIN exchange finished |
| ev_rx_valid | input | 1 | Any valid segment received |
| tx_unacked | input | 1 | A sent segment awaits acknowledgement |
| st_idle | output | 1 | Phase idle |
| st_listening | output | 1 | Phase listening |
| st_connecting | output | 1 | Phase connecting |
| st_connected | output | 1 | Phase connected |
| st_closing | output | 1 | Phase closing |
| rtx_req | output | 1 | Resend pulse |
| ka_req | output | 1 | Keepalive probe pulse |
| abort_req | output | 1 | Abort pulse |

## Verification
The hardest cases to reach from the ports are the collisions where a rescuing event lands in exactly the cycle its timer expires. Examples are an acknowledgement in the expiry cycle of the last resend, or a received segment in the cycle a probe would go out. Only one cycle in each run can produce such a collision. The stimulus therefore sweeps the position of the single rescuing event over every cycle of the resend, keepalive, handshake and teardown windows, with the intervals shortened to a few ticks. In each run the bench checks every cycle's pulses against times derived arithmetically from that event's position.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

  typedef enum logic [2:0] {
    PH_IDLE       = 3'd0,
    PH_LISTEN     = 3'd1,
    PH_CONNECTING = 3'd2,
    PH_CONNECTED  = 3'd3,
    PH_CLOSING    = 3'd4
  } phase_e;

  // Bits needed to hold a tick count up to lim (at least one bit).
  function automatic int unsigned cnt_width(input int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction

  // Phases that are bounded by the handshake/teardown deadline.
  function automatic logic is_transient(input phase_e p);
    return (p == PH_CONNECTING) || (p == PH_CLOSING);
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/tcs_tick_timer.sv
module tcs_tick_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         clr,
  input  logic [W-1:0] limit,
  output logic         hit
);
  logic [W-1:0] cnt;

  // hit does not look at clr so that callers may derive clr from hit
  assign hit = en && (cnt == limit - W'(1));

  always_ff @(posedge clk) begin
    if (rst || clr || !en || hit) cnt <= '0;
    else                          cnt <= cnt + W'(1);
  end

  // R3 R4 R6: count never runs past the active limit
  a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    en |-> (cnt < limit));

endmodule

// File: rtl/tcs_rtx_ctrl.sv
module tcs_rtx_ctrl #(
  parameter int unsigned RTX_TICKS = 1250000,
  parameter int unsigned RTX_TRIES = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic ev_ack,
  output logic rtx_req,
  output logic rtx_abort
);
  import tcs_pkg::*;
  localparam int unsigned TW = cnt_width(RTX_TICKS);
  localparam int unsigned NW = cnt_width(RTX_TRIES);

  logic          tick_hit;
  logic          expire;
  logic [NW-1:0] tries;

  tcs_tick_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst(rst), .en(active), .clr(ev_ack),
    .limit(TW'(RTX_TICKS)), .hit(tick_hit)
  );

  assign expire    = tick_hit && !ev_ack;
  assign rtx_req   = expire && (tries != NW'(RTX_TRIES));
  assign rtx_abort = expire && (tries == NW'(RTX_TRIES));

  always_ff @(posedge clk) begin
    if (rst || !active || ev_ack) tries <= '0;
    else if (rtx_req)             tries <= tries + NW'(1);
  end

  // R4: an acknowledgement suppresses any resend decision that cycle
  a_r4_ack_wins: assert property (@(posedge clk) disable iff (rst)
    ev_ack |-> !(rtx_req || rtx_abort));
  // R5: the resend count never passes its limit
  a_r5_tries_bounded: assert property (@(posedge clk) disable iff (rst)
    tries <= NW'(RTX_TRIES));
  // R4: requests are spaced by the interval, never back to back
  a_r4_req_spaced: assert property (@(posedge clk) disable iff (rst)
    rtx_req |=> !rtx_req);

endmodule

// File: rtl/tcs_keepalive.sv
module tcs_keepalive #(
  parameter bit          KA_ENABLE = 1'b1,
  parameter int unsigned KA_PERIOD = 625000000,
  parameter int unsigned KA_RETRY  = 12500000,
  parameter int unsigned KA_TRIES  = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic ev_rx,
  output logic ka_req,
  output logic ka_abort
);
  import tcs_pkg::*;
  localparam int unsigned TW = cnt_width(max2(KA_PERIOD, KA_RETRY));
  localparam int unsigned NW = cnt_width(KA_TRIES);

  generate
    if (KA_ENABLE) begin : g_ka
      logic          tick_hit;
      logic          expire;
      logic [NW-1:0] probes;
      logic [TW-1:0] limit;

      assign limit = (probes == '0) ? TW'(KA_PERIOD) : TW'(KA_RETRY);

      tcs_tick_timer #(.W(TW)) u_tmr (
        .clk(clk), .rst(rst), .en(active), .clr(ev_rx),
        .limit(limit), .hit(tick_hit)
      );

      assign expire   = tick_hit && !ev_rx;
      assign ka_req   = expire && (probes != NW'(KA_TRIES));
      assign ka_abort = expire && (probes == NW'(KA_TRIES));

      always_ff @(posedge clk) begin
        if (rst || !active || ev_rx) probes <= '0;
        else if (ka_req)             probes <= probes + NW'(1);
      end

      // R8: received traffic silences the prober that cycle
      a_r8_rx_silences: assert property (@(posedge clk) disable iff (rst)
        ev_rx |-> !(ka_req || ka_abort));
      // R7: probe count stays within its limit
      a_r7_probes_bounded: assert property (@(posedge clk) disable iff (rst)
        probes <= NW'(KA_TRIES));
      // R7: an abort only follows at least one unanswered probe
      a_r7_abort_needs_probe: assert property (@(posedge clk) disable iff (rst)
        ka_abort |-> (probes != '0));
    end else begin : g_noka
      assign ka_req   = 1'b0;
      assign ka_abort = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/tcs_phase_fsm.sv
module tcs_phase_fsm #(
  parameter int unsigned CONN_TIMEOUT_TICKS = 125000000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_connect,
  input  logic            cmd_listen,
  input  logic            cmd_close,
  input  logic            ev_synack,
  input  logic            ev_ack,
  input  logic            ev_fin_done,
  input  logic            ev_rx_valid,
  input  logic            rtx_abort,
  input  logic            ka_abort,
  output tcs_pkg::phase_e phase,
  output logic            abort_req
);
  import tcs_pkg::*;
  localparam int unsigned TW = cnt_width(CONN_TIMEOUT_TICKS);

  phase_e nxt;
  logic   tmo_hit;
  logic   tmo_abort;
  logic   link_abort;
  logic   phase_change;

  assign phase_change = (nxt != phase);

  tcs_tick_timer #(.W(TW)) u_deadline (
    .clk(clk), .rst(rst), .en(is_transient(phase)), .clr(phase_change),
    .limit(TW'(CONN_TIMEOUT_TICKS)), .hit(tmo_hit)
  );

  assign link_abort = (phase == PH_CONNECTED) && (rtx_abort || ka_abort);

  always_comb begin
    nxt       = phase;
    tmo_abort = 1'b0;
    unique case (phase)
      PH_IDLE: begin
        if (cmd_connect)     nxt = PH_CONNECTING;
        else if (cmd_listen) nxt = PH_LISTEN;
      end
      PH_LISTEN: begin
        if (cmd_close)        nxt = PH_IDLE;
        else if (ev_rx_valid) nxt = PH_CONNECTING;
      end
      PH_CONNECTING: begin
        if (ev_synack || ev_ack) nxt = PH_CONNECTED;
        else if (cmd_close)      nxt = PH_CLOSING;
        else if (tmo_hit) begin
          nxt       = PH_IDLE;
          tmo_abort = 1'b1;
        end
      end
      PH_CONNECTED: begin
        if (link_abort)     nxt = PH_IDLE;
        else if (cmd_close) nxt = PH_CLOSING;
      end
      PH_CLOSING: begin
        if (ev_fin_done) nxt = PH_IDLE;
        else if (tmo_hit) begin
          nxt       = PH_IDLE;
          tmo_abort = 1'b1;
        end
      end
      default: nxt = PH_IDLE;
    endcase
  end

  assign abort_req = tmo_abort || link_abort;

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_IDLE;
    else     phase <= nxt;
  end

  // R10: an abort returns to idle on the next cycle and lasts one cycle
  a_r10_abort_to_idle: assert property (@(posedge clk) disable iff (rst)
    abort_req |=> (phase == PH_IDLE));
  a_r10_abort_single: assert property (@(posedge clk) disable iff (rst)
    abort_req |=> !abort_req);
  // R3: the deadline only fires in the bounded phases, never while listening
  a_r3_deadline_phase: assert property (@(posedge clk) disable iff (rst)
    tmo_hit |-> is_transient(phase));
  a_r3_listen_no_abort: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_LISTEN) |-> !abort_req);

endmodule

// File: rtl/tcp_conn_supervisor.sv
module tcp_conn_supervisor #(
  parameter int unsigned RTX_TICKS          = 1250000,
  parameter int unsigned RTX_TRIES          = 5,
  parameter int unsigned CONN_TIMEOUT_TICKS = 125000000,
  parameter int unsigned KA_PERIOD_TICKS    = 625000000,
  parameter int unsigned KA_RETRY_TICKS     = 12500000,
  parameter int unsigned KA_TRIES           = 5,
  parameter bit          KA_ENABLE          = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd_connect,
  input  logic cmd_listen,
  input  logic cmd_close,
  input  logic ev_synack,
  input  logic ev_ack,
  input  logic ev_fin_done,
  input  logic ev_rx_valid,
  input  logic tx_unacked,
  output logic st_idle,
  output logic st_listening,
  output logic st_connecting,
  output logic st_connected,
  output logic st_closing,
  output logic rtx_req,
  output logic ka_req,
  output logic abort_req
);
  import tcs_pkg::*;

  phase_e phase;
  logic   connected;
  logic   rtx_active;
  logic   rtx_abort;
  logic   ka_abort;
  logic   rtx_pulse;
  logic   ka_pulse;

  assign connected  = (phase == PH_CONNECTED);
  assign rtx_active = connected && tx_unacked;

  tcs_phase_fsm #(.CONN_TIMEOUT_TICKS(CONN_TIMEOUT_TICKS)) u_fsm (
    .clk(clk), .rst(rst),
    .cmd_connect(cmd_connect), .cmd_listen(cmd_listen), .cmd_close(cmd_close),
    .ev_synack(ev_synack), .ev_ack(ev_ack), .ev_fin_done(ev_fin_done),
    .ev_rx_valid(ev_rx_valid), .rtx_abort(rtx_abort), .ka_abort(ka_abort),
    .phase(phase), .abort_req(abort_req)
  );

  tcs_rtx_ctrl #(.RTX_TICKS(RTX_TICKS), .RTX_TRIES(RTX_TRIES)) u_rtx (
    .clk(clk), .rst(rst), .active(rtx_active), .ev_ack(ev_ack),
    .rtx_req(rtx_pulse), .rtx_abort(rtx_abort)
  );

  tcs_keepalive #(
    .KA_ENABLE(KA_ENABLE), .KA_PERIOD(KA_PERIOD_TICKS),
    .KA_RETRY(KA_RETRY_TICKS), .KA_TRIES(KA_TRIES)
  ) u_ka (
    .clk(clk), .rst(rst), .active(connected), .ev_rx(ev_rx_valid),
    .ka_req(ka_pulse), .ka_abort(ka_abort)
  );

  assign rtx_req = rtx_pulse;
  assign ka_req  = ka_pulse;

  assign st_idle       = (phase == PH_IDLE);
  assign st_listening  = (phase == PH_LISTEN);
  assign st_connecting = (phase == PH_CONNECTING);
  assign st_connected  = connected;
  assign st_closing    = (phase == PH_CLOSING);

  // R1: status flags are one-hot
  a_r1_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot({st_idle, st_listening, st_connecting, st_connected, st_closing}));
  // R4 R6: requests come only from the connected phase
  a_r6_req_connected: assert property (@(posedge clk) disable iff (rst)
    (rtx_req || ka_req) |-> connected);
  // R9: with keepalive off no probe is ever requested
  a_r9_ka_off: assert property (@(posedge clk) disable iff (rst)
    !KA_ENABLE |-> !ka_req);

endmodule

// File: tb/tcp_conn_supervisor_tb.sv
module tcp_conn_supervisor_tb;
  localparam int RTX  = 8;
  localparam int RTRY = 3;
  localparam int CTMO = 20;
  localparam int KP   = 16;
  localparam int KR   = 6;
  localparam int KTRY = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_connect = 0, cmd_listen = 0, cmd_close = 0;
  logic ev_synack = 0, ev_ack = 0, ev_fin_done = 0, ev_rx_valid = 0, tx_unacked = 0;
  logic st_idle, st_listening, st_connecting, st_connected, st_closing;
  logic rtx_req, ka_req, abort_req;
  logic n_idle, n_listening, n_connecting, n_connected, n_closing;
  logic n_rtx, n_ka, n_abort;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  tcp_conn_supervisor #(
    .RTX_TICKS(RTX), .RTX_TRIES(RTRY), .CONN_TIMEOUT_TICKS(CTMO),
    .KA_PERIOD_TICKS(KP), .KA_RETRY_TICKS(KR), .KA_TRIES(KTRY), .KA_ENABLE(1'b1)
  ) u_dut (
    .clk(clk), .rst(rst), .cmd_connect(cmd_connect), .cmd_listen(cmd_listen),
    .cmd_close(cmd_close), .ev_synack(ev_synack), .ev_ack(ev_ack),
    .ev_fin_done(ev_fin_done), .ev_rx_valid(ev_rx_valid), .tx_unacked(tx_unacked),
    .st_idle(st_idle), .st_listening(st_listening), .st_connecting(st_connecting),
    .st_connected(st_connected), .st_closing(st_closing),
    .rtx_req(rtx_req), .ka_req(ka_req), .abort_req(abort_req)
  );

  tcp_conn_supervisor #(
    .RTX_TICKS(RTX), .RTX_TRIES(RTRY), .CONN_TIMEOUT_TICKS(CTMO),
    .KA_PERIOD_TICKS(KP), .KA_RETRY_TICKS(KR), .KA_TRIES(KTRY), .KA_ENABLE(1'b0)
  ) u_dut_noka (
    .clk(clk), .rst(rst), .cmd_connect(cmd_connect), .cmd_listen(cmd_listen),
    .cmd_close(cmd_close), .ev_synack(ev_synack), .ev_ack(ev_ack),
    .ev_fin_done(ev_fin_done), .ev_rx_valid(ev_rx_valid), .tx_unacked(tx_unacked),
    .st_idle(n_idle), .st_listening(n_listening), .st_connecting(n_connecting),
    .st_connected(n_connected), .st_closing(n_closing),
    .rtx_req(n_rtx), .ka_req(n_ka), .abort_req(n_abort)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int st_code();
    return {st_closing, st_connected, st_connecting, st_listening, st_idle};
  endfunction

  task automatic clear_in();
    cmd_connect = 0; cmd_listen = 0; cmd_close = 0;
    ev_synack = 0; ev_ack = 0; ev_fin_done = 0; ev_rx_valid = 0; tx_unacked = 0;
  endtask

  task automatic do_reset();
    clear_in();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 reset idle", st_code(), 1);
  endtask

  task automatic go_connected();
    cmd_connect = 1;
    @(negedge clk);
    cmd_connect = 0; ev_synack = 1;
    @(negedge clk);
    ev_synack = 0;
    #1;
    chk("R2 reach connected", st_code(), 8);
  endtask

  // expected resend pulses, t = cycles since interval start (first = 1)
  task automatic rtx_exp(input int t, output bit p, output bit a);
    p = 0; a = 0;
    if (t % RTX == 0) begin
      if (t / RTX <= RTRY) p = 1;
      else if (t / RTX == RTRY + 1) a = 1;
    end
  endtask

  task automatic ka_exp(input int t, output bit p, output bit a);
    p = 0; a = 0;
    if (t == KP) p = 1;
    else if (t > KP && (t - KP) % KR == 0) begin
      if ((t - KP) / KR < KTRY) p = 1;
      else if ((t - KP) / KR == KTRY) a = 1;
    end
  endtask

  // R4 R5: resend schedule with one ack at cycle j (0 = none)
  task automatic rtx_run(input int j);
    bit p, a;
    do_reset();
    go_connected();
    for (int k = 1; k <= 400; k++) begin
      tx_unacked = 1; ev_rx_valid = 1; ev_ack = (k == j);
      if (k < j)       rtx_exp(k, p, a);
      else if (k == j) begin p = 0; a = 0; end
      else             rtx_exp(k - j, p, a);
      #1;
      chk("R4 rtx_req", rtx_req, p);
      chk("R5 rtx abort", abort_req, a);
      if (a) begin
        @(negedge clk); #1;
        chk("R10 idle after rtx abort", st_code(), 1);
        chk("R10 abort single", abort_req, 0);
        break;
      end
      @(negedge clk);
    end
    clear_in();
  endtask

  // R6 R7 R8 R9: keepalive schedule with one rx at cycle j (0 = none)
  task automatic ka_run(input int j);
    bit p, a;
    do_reset();
    go_connected();
    for (int k = 1; k <= 400; k++) begin
      ev_rx_valid = (k == j);
      if (k < j)       ka_exp(k, p, a);
      else if (k == j) begin p = 0; a = 0; end
      else             ka_exp(k - j, p, a);
      #1;
      chk("R6 R7 R8 ka_req", ka_req, p);
      chk("R7 ka abort", abort_req, a);
      chk("R9 no probe when disabled", n_ka, 0);
      if (a) begin
        @(negedge clk); #1;
        chk("R10 idle after ka abort", st_code(), 1);
        chk("R9 disabled stays connected", n_connected, 1);
        break;
      end
      @(negedge clk);
    end
    clear_in();
  endtask

  // R3: handshake deadline, synack at cycle j (> CTMO = none)
  task automatic conn_tmo_run(input int j);
    do_reset();
    cmd_connect = 1;
    @(negedge clk);
    cmd_connect = 0;
    for (int k = 1; k <= CTMO; k++) begin
      ev_synack = (k == j);
      #1;
      chk("R3 connect deadline", abort_req, (k == CTMO && j > CTMO) ? 1 : 0);
      @(negedge clk);
      ev_synack = 0;
      if (k == j) break;
    end
    #1;
    chk("R3 connect outcome", st_code(), (j <= CTMO) ? 8 : 1);
    clear_in();
  endtask

  // R3: teardown deadline, fin_done at cycle j (> CTMO = none)
  task automatic close_tmo_run(input int j);
    do_reset();
    go_connected();
    cmd_close = 1;
    @(negedge clk);
    cmd_close = 0;
    #1;
    chk("R2 connected to closing", st_code(), 16);
    for (int k = 1; k <= CTMO; k++) begin
      ev_fin_done = (k == j);
      #1;
      chk("R3 close deadline", abort_req, (k == CTMO && j > CTMO) ? 1 : 0);
      @(negedge clk);
      ev_fin_done = 0;
      if (k == j) break;
    end
    #1;
    chk("R3 close outcome", st_code(), 1);
    clear_in();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    // R2: connect wins over listen
    do_reset();
    cmd_connect = 1; cmd_listen = 1;
    @(negedge clk); clear_in(); #1;
    chk("R2 connect priority", st_code(), 4);

    // R2: listen path, no deadline while listening (R3)
    do_reset();
    cmd_listen = 1;
    @(negedge clk); clear_in(); #1;
    chk("R2 idle to listening", st_code(), 2);
    for (int k = 0; k < 3 * CTMO; k++) begin
      ev_synack = 1;
      #1;
      chk("R3 listening no abort", abort_req, 0);
      @(negedge clk);
    end
    ev_synack = 0; #1;
    chk("R2 synack ignored in listening", st_code(), 2);
    ev_rx_valid = 1;
    @(negedge clk); ev_rx_valid = 0; #1;
    chk("R2 listening to connecting", st_code(), 4);
    ev_ack = 1;
    @(negedge clk); ev_ack = 0; #1;
    chk("R2 connecting to connected by ack", st_code(), 8);

    do_reset();
    cmd_listen = 1;
    @(negedge clk); clear_in();
    cmd_close = 1;
    @(negedge clk); clear_in(); #1;
    chk("R2 listening close to idle", st_code(), 1);

    do_reset();
    cmd_connect = 1;
    @(negedge clk); clear_in();
    cmd_close = 1;
    @(negedge clk); clear_in(); #1;
    chk("R2 connecting to closing", st_code(), 16);

    for (int j = 1; j <= CTMO + 1; j++) conn_tmo_run(j);
    for (int j = 1; j <= CTMO + 1; j++) close_tmo_run(j);
    rtx_run(0);
    for (int j = 1; j <= RTX * RTRY + RTX; j++) rtx_run(j);
    ka_run(0);
    for (int j = 1; j <= KP + KTRY * KR; j++) ka_run(j);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule